// File: doc/BRIEF.md
# Hex Float / Integer Converter

This block converts between 32-bit two's-complement integers and 32-bit base-16 floating-point words. A float word has a sign in bit 31, a 7-bit exponent with a bias of 64 in bits 30..24, and a 24-bit fraction made of six hex digits in bits 23..0. Its value is 0.fraction × 16^(exponent − 64). A negative float is the two's complement of the whole positive word.

A one-cycle `start_i` pulse loads the operand and selects the direction through `mode_i`. The block first takes the magnitude of a negative operand by whole-word negation. It then moves the value one hex digit per clock. Last, it restores the sign, again by whole-word negation. The result and a one-hot 4-bit condition code come back together with a single-cycle `done_o` pulse. A caller issues one conversion and waits for `done_o` before it issues the next.

Top module: `hexcvt_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no conversion yet, `done_o` is 0, `result_o` is 0 and `cc_o` is 0.
- R2: With `mode_i`=0 (float to integer), a positive float with exponent e (64 ≤ e ≤ 72) gives the integer part of its value. That is the fraction placed in bits 31..8 and shifted right by 4×(72−e) bits.
- R3: An operand with bit 31 set is negated (bitwise inversion plus one) before conversion, and the result is negated the same way afterwards. This holds in both directions.
- R4: An all-zero operand gives an all-zero result and `cc_o`=4'b0001 in both directions. A float whose fraction is zero also gives integer 0.
- R5: In float to integer, a magnitude with exponent above 72, or with exponent 72 and fraction bit 23 set, gives `result_o`=32'h7FFFFFFF and `cc_o`=4'b1000, whatever the sign.
- R6: A float with exponent below 65, whose magnitude is less than one, converts to integer 0 with `cc_o`=4'b0001.
- R7: With `mode_i`=1 (integer to float), the magnitude is shifted left one hex digit at a time until bits 31..28 are nonzero, with n shifts counted. The result is {0, exponent 72−n in bits 30..24, bits 31..8 of the shifted value}, and the bits below are dropped.
- R8: Integer to float never sets `cc_o[3]`. The magnitude 2^31 converts to 32'hB7800000.
- R9: `cc_o` is one-hot whenever `done_o` is high. Bit 3 means overflow, bit 2 a positive result, bit 1 a negative result (bit 31 set) and bit 0 a zero result.
- R10: `done_o` is high for exactly one cycle, no more than 12 clock cycles after the edge that accepted `start_i`.
- R11: A `start_i` pulse that arrives while a conversion is in progress has no effect. The running conversion completes with its own operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a conversion when the block is idle |
| mode_i | input | 1 | 0: float to integer, 1: integer to float |
| operand_i | input | 32 | Word to convert, sampled with `start_i` |
| result_o | output | 32 | Converted word, valid with `done_o` |
| cc_o | output | 4 | Condition code: overflow, positive, negative, zero |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each conversion walks the digit loop for a number of cycles that depends on its data. A wrong shift count or a lost sign flag therefore shows up as a wrong result word on the same `done_o` pulse. A stuck loop shows up as a missing pulse within 12 cycles. Each category of the condition code has its own vectors: saturation, values below one, zero operands and the asymmetric magnitude 2^31. Each category fixes the output word exactly. A second start during a busy conversion would corrupt the captured operand, and the result word of the first conversion reveals it.

// File: rtl/hexcvt_pkg.sv
package hexcvt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_SHIFT,
    ST_FIN
  } cvt_state_e;

  localparam int CC_OVF = 3;
  localparam int CC_POS = 2;
  localparam int CC_NEG = 1;
  localparam int CC_ZER = 0;

endpackage

// File: rtl/hexcvt_negate.sv
module hexcvt_negate #(
  parameter int WORD_W = 32
) (
  input  logic              neg_i,
  input  logic [WORD_W-1:0] val_i,
  output logic [WORD_W-1:0] val_o
);

  always_comb begin
    if (neg_i) val_o = ~val_i + WORD_W'(1);
    else       val_o = val_i;
  end

endmodule

// File: rtl/hexcvt_cc_enc.sv
module hexcvt_cc_enc
  import hexcvt_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              ovf_i,
  input  logic [WORD_W-1:0] val_i,
  output logic [3:0]        cc_o
);

  always_comb begin
    cc_o = '0;
    if (ovf_i)                 cc_o[CC_OVF] = 1'b1;
    else if (val_i == '0)      cc_o[CC_ZER] = 1'b1;
    else if (val_i[WORD_W-1])  cc_o[CC_NEG] = 1'b1;
    else                       cc_o[CC_POS] = 1'b1;
  end

endmodule

// File: rtl/hexcvt_f2i_prep.sv
module hexcvt_f2i_prep #(
  parameter int WORD_W   = 32,
  parameter int EXP_W    = 7,
  parameter int FRAC_W   = 24,
  parameter int DIGIT_W  = 4,
  parameter int EXP_BIAS = 64,
  parameter int CNT_W    = 4
) (
  input  logic [WORD_W-1:0] mag_i,
  output logic              zero_o,
  output logic              ovf_o,
  output logic [WORD_W-1:0] work_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam int DIGITS  = WORD_W / DIGIT_W;
  localparam int INT_EXP = EXP_BIAS + DIGITS;
  localparam int PAD_W   = WORD_W - FRAC_W;

  logic [EXP_W:0]    exp_v;
  logic [FRAC_W-1:0] frac_v;
  logic [EXP_W:0]    dist_v;

  assign exp_v  = {1'b0, mag_i[WORD_W-2 -: EXP_W]};
  assign frac_v = mag_i[FRAC_W-1:0];
  assign dist_v = (EXP_W+1)'(INT_EXP) - exp_v;

  always_comb begin
    zero_o = 1'b0;
    ovf_o  = 1'b0;
    work_o = {frac_v, {PAD_W{1'b0}}};
    cnt_o  = '0;
    if (frac_v == '0) begin
      zero_o = 1'b1;
    end else if (mag_i[WORD_W-1] || exp_v > (EXP_W+1)'(INT_EXP)) begin
      ovf_o = 1'b1;
    end else if (exp_v == (EXP_W+1)'(INT_EXP) && frac_v[FRAC_W-1]) begin
      ovf_o = 1'b1;
    end else if (dist_v >= (EXP_W+1)'(DIGITS)) begin
      zero_o = 1'b1;
    end else begin
      cnt_o = CNT_W'(dist_v);
    end
  end

endmodule

// File: rtl/hexcvt_top.sv
module hexcvt_top
  import hexcvt_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int EXP_W    = 7,
  parameter int FRAC_W   = 24,
  parameter int DIGIT_W  = 4,
  parameter int EXP_BIAS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] operand_i,
  output logic [WORD_W-1:0] result_o,
  output logic [3:0]        cc_o,
  output logic              done_o
);

  localparam int DIGITS  = WORD_W / DIGIT_W;
  localparam int INT_EXP = EXP_BIAS + DIGITS;
  localparam int CNT_W   = $clog2(DIGITS + 1);
  localparam int MAX_BUSY = DIGITS + 2;
  localparam logic [WORD_W-1:0] SAT_VAL = {1'b0, {(WORD_W-1){1'b1}}};

  cvt_state_e        state_q, state_d;
  logic              mode_q, mode_d;
  logic              neg_q, neg_d;
  logic              zero_q, zero_d;
  logic              ovf_q, ovf_d;
  logic [WORD_W-1:0] work_q, work_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] result_q, result_d;
  logic [3:0]        cc_q, cc_d;
  logic              done_q, done_d;

  logic [WORD_W-1:0] mag_in;
  logic              p_zero, p_ovf;
  logic [WORD_W-1:0] p_work;
  logic [CNT_W-1:0]  p_cnt;
  logic [EXP_W-1:0]  exp_out;
  logic [WORD_W-1:0] pos_word, signed_word, final_word;
  logic [3:0]        cc_calc;

  // sign removal on entry
  hexcvt_negate #(.WORD_W(WORD_W)) u_neg_in (
    .neg_i (operand_i[WORD_W-1]),
    .val_i (operand_i),
    .val_o (mag_in)
  );

  hexcvt_f2i_prep #(
    .WORD_W(WORD_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W),
    .DIGIT_W(DIGIT_W), .EXP_BIAS(EXP_BIAS), .CNT_W(CNT_W)
  ) u_prep (
    .mag_i  (work_q),
    .zero_o (p_zero),
    .ovf_o  (p_ovf),
    .work_o (p_work),
    .cnt_o  (p_cnt)
  );

  assign exp_out  = EXP_W'(INT_EXP) - EXP_W'(cnt_q);
  assign pos_word = mode_q ? {1'b0, exp_out, work_q[WORD_W-1 -: FRAC_W]} : work_q;

  // sign restore on exit
  hexcvt_negate #(.WORD_W(WORD_W)) u_neg_out (
    .neg_i (neg_q),
    .val_i (pos_word),
    .val_o (signed_word)
  );

  assign final_word = ovf_q ? SAT_VAL : (zero_q ? '0 : signed_word);

  hexcvt_cc_enc #(.WORD_W(WORD_W)) u_cc (
    .ovf_i (ovf_q),
    .val_i (final_word),
    .cc_o  (cc_calc)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    neg_d    = neg_q;
    zero_d   = zero_q;
    ovf_d    = ovf_q;
    work_d   = work_q;
    cnt_d    = cnt_q;
    result_d = result_q;
    cc_d     = cc_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d  = mode_i;
          neg_d   = operand_i[WORD_W-1];
          work_d  = mag_in;
          state_d = ST_PREP;
        end
      end
      ST_PREP: begin
        if (!mode_q) begin
          zero_d = p_zero;
          ovf_d  = p_ovf;
          work_d = p_work;
          cnt_d  = p_cnt;
        end else begin
          zero_d = (work_q == '0);
          ovf_d  = 1'b0;
          cnt_d  = '0;
        end
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (zero_q || ovf_q) begin
          state_d = ST_FIN;
        end else if (!mode_q) begin
          if (cnt_q != '0) begin
            work_d = work_q >> DIGIT_W;
            cnt_d  = cnt_q - CNT_W'(1);
          end else begin
            state_d = ST_FIN;
          end
        end else begin
          if (work_q[WORD_W-1 -: DIGIT_W] == '0) begin
            work_d = work_q << DIGIT_W;
            cnt_d  = cnt_q + CNT_W'(1);
          end else begin
            state_d = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        result_d = final_word;
        cc_d     = cc_calc;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      neg_q    <= 1'b0;
      zero_q   <= 1'b0;
      ovf_q    <= 1'b0;
      work_q   <= '0;
      cnt_q    <= '0;
      result_q <= '0;
      cc_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      neg_q    <= neg_d;
      zero_q   <= zero_d;
      ovf_q    <= ovf_d;
      work_q   <= work_d;
      cnt_q    <= cnt_d;
      result_q <= result_d;
      cc_q     <= cc_d;
      done_q   <= done_d;
    end
  end

  assign result_o = result_q;
  assign cc_o     = cc_q;
  assign done_o   = done_q;

  // busy-time counter for the latency check
  logic [CNT_W+1:0] busy_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt_q <= '0;
    else if (state_q == ST_IDLE) busy_cnt_q <= '0;
    else                       busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt_q <= (CNT_W+2)'(MAX_BUSY));

  // R9
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones(cc_o) == 1);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q) |-> !cc_o[CC_OVF]);

  // R5
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cc_o[CC_OVF]) |-> result_o == SAT_VAL);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(mode_q) && $stable(neg_q)));

endmodule

// File: tb/hexcvt_top_tb_top.sv
`timescale 1ns/1ps
module hexcvt_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        mode_i;
  logic [31:0] operand_i;
  logic [31:0] result_o;
  logic [3:0]  cc_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;

  hexcvt_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .operand_i (operand_i),
    .result_o  (result_o),
    .cc_o      (cc_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {mode, operand, expected result, expected cc}
  localparam int NV = 19;
  localparam logic [68:0] VECS [NV] = '{
    {1'b0, 32'h41100000, 32'h00000001, 4'b0100}, // R2
    {1'b0, 32'h42640000, 32'h00000064, 4'b0100}, // R2
    {1'b0, 32'h46123456, 32'h00123456, 4'b0100}, // R2
    {1'b0, 32'h487FFFFF, 32'h7FFFFF00, 4'b0100}, // R2
    {1'b0, 32'hBD9C0000, 32'hFFFFFF9C, 4'b0010}, // R3
    {1'b0, 32'h00000000, 32'h00000000, 4'b0001}, // R4
    {1'b0, 32'h48800000, 32'h7FFFFFFF, 4'b1000}, // R5
    {1'b0, 32'h49100000, 32'h7FFFFFFF, 4'b1000}, // R5
    {1'b0, 32'hB6F00000, 32'h7FFFFFFF, 4'b1000}, // R5
    {1'b0, 32'h40800000, 32'h00000000, 4'b0001}, // R6
    {1'b0, 32'hBF800000, 32'h00000000, 4'b0001}, // R6
    {1'b1, 32'h00000001, 32'h41100000, 4'b0100}, // R7
    {1'b1, 32'h00000064, 32'h42640000, 4'b0100}, // R7
    {1'b1, 32'h00123456, 32'h46123456, 4'b0100}, // R7
    {1'b1, 32'h12345678, 32'h48123456, 4'b0100}, // R7
    {1'b1, 32'hFFFFFF9C, 32'hBD9C0000, 4'b0010}, // R3
    {1'b1, 32'h00000000, 32'h00000000, 4'b0001}, // R4
    {1'b1, 32'h7FFFFFFF, 32'h487FFFFF, 4'b0100}, // R8
    {1'b1, 32'h80000000, 32'hB7800000, 4'b0010}  // R8
  };
  localparam string TAGS [NV] = '{
    "R2", "R2", "R2", "R2", "R3", "R4", "R5", "R5", "R5", "R6", "R6",
    "R7", "R7", "R7", "R7", "R3", "R4", "R8", "R8"
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic m, input logic [31:0] op);
    @(negedge clk);
    start_i   = 1'b1;
    mode_i    = m;
    operand_i = op;
    @(negedge clk);
    start_i   = 1'b0;
  endtask

  // waits for done; returns the number of cycles counted since the start edge
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done_o && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_vec(input logic m, input logic [31:0] op,
                         input logic [31:0] exp_res, input logic [3:0] exp_cc,
                         input string tag);
    int cyc;
    pulse_start(m, op);
    wait_done(cyc);
    check(tag, "done seen", {31'b0, done_o}, 32'h1);
    check(tag, "result", result_o, exp_res);
    check("R9", "cc", {28'b0, cc_o}, {28'b0, exp_cc});
    check("R10", "latency within 12", {31'b0, (cyc <= 12)}, 32'h1);
    @(negedge clk);
    check("R10", "done one cycle", {31'b0, done_o}, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    mode_i    = 1'b0;
    operand_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "done in reset", {31'b0, done_o}, 32'h0);
    check("R1", "result in reset", result_o, 32'h0);
    check("R1", "cc in reset", {28'b0, cc_o}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release
    check("R1", "done idle", {31'b0, done_o}, 32'h0);
    check("R1", "result idle", result_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i][68], VECS[i][67:36], VECS[i][35:4], VECS[i][3:0], TAGS[i]);
    end

    // R11: second start during a busy conversion is dropped
    begin
      int cyc;
      pulse_start(1'b1, 32'h00000064);
      pulse_start(1'b0, 32'h41100000);
      wait_done(cyc);
      check("R11", "busy start ignored result", result_o, 32'h42640000);
      check("R11", "busy start ignored cc", {28'b0, cc_o}, 32'h4);
      @(negedge clk);
      check("R11", "no extra done", {31'b0, done_o}, 32'h0);
      repeat (15) @(negedge clk);
      check("R11", "no late done", {31'b0, done_o}, 32'h0);
    end

    // back-to-back conversions after the dropped start
    run_vec(1'b0, 32'h42640000, 32'h00000064, 4'b0100, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule